// File: doc/BRIEF.md
# SPI Register Message Controller

This block sits above an SPI slave byte transceiver and turns the byte stream exchanged with the bus master into framed register transactions. Each time the transceiver finishes a byte exchange, it raises a one-cycle strobe with the byte received from the master. The controller presents, on `tx_byte`, the byte that the transceiver shifts out during the next exchange. The register side drives a bank of read/write words and samples a bank of read-only words. Read/write words take the low indices and read-only words follow at once after them.

A four-state machine runs each message and uses a down-counting byte index. The states are `ST_IDLE` (0), `ST_SEND_STAT` (1), `ST_SEND_WORD` (2) and `ST_RECV_WORD` (3). In `ST_IDLE`, a strobed byte is taken as a command. The value 0x7F moves to `ST_SEND_STAT`. A command with bit 7 clear moves to `ST_SEND_WORD` and latches the addressed word. A command with bit 7 set moves to `ST_RECV_WORD`. `ST_SEND_STAT` returns to `ST_IDLE` on the next strobe. `ST_SEND_WORD` and `ST_RECV_WORD` count the byte index down on each strobe and return to `ST_IDLE` after byte 0. A chip-select release pulse returns any state to `ST_IDLE`.

Top module: `spireg_msg_ctrl`

## Requirements
- R1: After reset the machine is idle, `tx_byte` is 0x00, every read/write word is zero and the status error bit is clear.
- R2: A command byte uses bit 7 to choose write (1) or read (0) and bits 6:0 as the register index. The byte 0x7F alone requests status, and the machine then presents the status byte on `tx_byte` from the next cycle.
- R3: The status byte is {7'b0, err}. The strobe that completes the status exchange returns the machine to idle and clears err.
- R4: A read sends the word over four exchanges, most significant byte first, with the byte index counting down 3, 2, 1, 0. `tx_byte` returns to 0x00 (idle) after the fourth strobe.
- R5: Indices 0 to NUM_RW-1 address the read/write words. Indices NUM_RW to NUM_RW+NUM_RO-1 address read-only word (index-NUM_RW).
- R6: A read of any index at or above NUM_RW+NUM_RO returns DEFAULT_RD (0xDEADBEEF by default).
- R7: The word sent by a read is captured in the cycle the command is accepted. Later changes on `ro_regs_i` do not alter the bytes of that transfer.
- R8: A write gathers four data bytes, most significant first. On the fourth strobe it stores the word into the addressed read/write register, and the word is visible on `rw_regs_o` in the next cycle.
- R9: A write to a read-only or out-of-range index changes no register and sets err.
- R10: A `cs_release` pulse returns the machine to idle and clears the byte index, even when a strobe arrives in the same cycle. A partial write is dropped, and the next strobe is decoded as a new command.
- R11: In cycles without a strobe, state, byte index and `tx_byte` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid | input | 1 | One-cycle strobe: a byte exchange has finished |
| rx_byte | input | 8 | Byte received from the master |
| cs_release | input | 1 | Pulse on chip-select deassertion, aborts the message |
| tx_byte | output | 8 | Byte to shift toward the master on the next exchange |
| ro_regs_i | input | NUM_RO*32 | Read-only words, word i at bits 32*i+31:32*i |
| rw_regs_o | output | NUM_RW*32 | Read/write words, word i at bits 32*i+31:32*i |

## Verification
The bench builds the controller with NUM_RW=5 and NUM_RO=3. Neither count is a power of two, so the boundary between the two banks falls at index 5 and the first out-of-range index is 8. Both limits are hit by directed reads and writes. Random traffic mixes status, read and write commands and idle gaps, and sometimes uses indices far above the banks. Directed cases cover three more situations: a read-only input that changes in the middle of a transfer, an aborted partial write, and an abort that coincides with a command strobe while err is set.

// File: rtl/spireg_pkg.sv
package spireg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_SEND_STAT = 2'd1,
        ST_SEND_WORD = 2'd2,
        ST_RECV_WORD = 2'd3
    } msg_state_e;

    typedef enum logic [1:0] {
        CMD_STATUS = 2'd0,
        CMD_READ   = 2'd1,
        CMD_WRITE  = 2'd2
    } cmd_kind_e;

    typedef enum logic [1:0] {
        RGN_RW   = 2'd0,
        RGN_RO   = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

    localparam logic [7:0] STATUS_REQ = 8'h7F;
    localparam int         IDX_BITS   = 7;

endpackage

// File: rtl/spireg_cmd_decode.sv
module spireg_cmd_decode
    import spireg_pkg::*;
#(
    parameter int NUM_RW = 4,
    parameter int NUM_RO = 4
) (
    input  logic [7:0]          cmd,
    output cmd_kind_e           kind,
    output logic [IDX_BITS-1:0] index,
    output region_e             region
);
    localparam logic [7:0] RW_END = 8'(NUM_RW);
    localparam logic [7:0] RO_END = 8'(NUM_RW + NUM_RO);

    always_comb begin
        index = cmd[IDX_BITS-1:0];
        if (cmd == STATUS_REQ) begin
            kind = CMD_STATUS;
        end else if (cmd[7]) begin
            kind = CMD_WRITE;
        end else begin
            kind = CMD_READ;
        end
        if ({1'b0, index} < RW_END) begin
            region = RGN_RW;
        end else if ({1'b0, index} < RO_END) begin
            region = RGN_RO;
        end else begin
            region = RGN_NONE;
        end
    end

endmodule

// File: rtl/spireg_read_mux.sv
module spireg_read_mux
    import spireg_pkg::*;
#(
    parameter int          NUM_RW     = 4,
    parameter int          NUM_RO     = 4,
    parameter int          WORD_W     = 32,
    parameter logic [31:0] DEFAULT_RD = 32'hDEADBEEF
) (
    input  logic [NUM_RW*WORD_W-1:0] rw_flat,
    input  logic [NUM_RO*WORD_W-1:0] ro_flat,
    input  logic [IDX_BITS-1:0]      index,
    input  region_e                  region,
    output logic [WORD_W-1:0]        word
);
    logic [WORD_W-1:0] rw_arr [NUM_RW];
    logic [WORD_W-1:0] ro_arr [NUM_RO];

    for (genvar g = 0; g < NUM_RW; g++) begin : g_rw_unpack
        assign rw_arr[g] = rw_flat[g*WORD_W +: WORD_W];
    end
    for (genvar g = 0; g < NUM_RO; g++) begin : g_ro_unpack
        assign ro_arr[g] = ro_flat[g*WORD_W +: WORD_W];
    end

    always_comb begin
        word = WORD_W'(DEFAULT_RD);
        for (int i = 0; i < NUM_RW; i++) begin
            if (region == RGN_RW && index == IDX_BITS'(i)) begin
                word = rw_arr[i];
            end
        end
        for (int i = 0; i < NUM_RO; i++) begin
            if (region == RGN_RO && index == IDX_BITS'(NUM_RW + i)) begin
                word = ro_arr[i];
            end
        end
    end

endmodule

// File: rtl/spireg_rw_bank.sv
module spireg_rw_bank
    import spireg_pkg::*;
#(
    parameter int NUM_RW = 4,
    parameter int WORD_W = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [IDX_BITS-1:0]      wr_idx,
    input  logic [WORD_W-1:0]        wr_data,
    output logic [NUM_RW*WORD_W-1:0] regs_flat
);
    for (genvar g = 0; g < NUM_RW; g++) begin : g_word
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (wr_en && wr_idx == IDX_BITS'(g)) begin
                q <= wr_data;
            end
        end
        assign regs_flat[g*WORD_W +: WORD_W] = q;
    end

    assert_wr_in_rw_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < 8'(NUM_RW)));

endmodule

// File: rtl/spireg_msg_ctrl.sv
module spireg_msg_ctrl
    import spireg_pkg::*;
#(
    parameter int          NUM_RW     = 4,
    parameter int          NUM_RO     = 4,
    parameter int          WORD_W     = 32,
    parameter logic [31:0] DEFAULT_RD = 32'hDEADBEEF
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rx_valid,
    input  logic [7:0]               rx_byte,
    input  logic                     cs_release,
    output logic [7:0]               tx_byte,
    input  logic [NUM_RO*WORD_W-1:0] ro_regs_i,
    output logic [NUM_RW*WORD_W-1:0] rw_regs_o
);
    localparam int              NBYTES = WORD_W / 8;
    localparam int              BIDX_W = (NBYTES > 1) ? $clog2(NBYTES) : 1;
    localparam logic [BIDX_W-1:0] LAST_BYTE = BIDX_W'(NBYTES - 1);

    msg_state_e          state_q, state_d;
    logic [BIDX_W-1:0]   bidx_q, bidx_d;
    logic [WORD_W-1:0]   shadow_q, shadow_d;
    logic [IDX_BITS-1:0] tgt_idx_q, tgt_idx_d;
    region_e             tgt_rgn_q, tgt_rgn_d;
    logic                err_q, err_d;

    cmd_kind_e           dec_kind;
    logic [IDX_BITS-1:0] dec_idx;
    region_e             dec_rgn;
    logic [WORD_W-1:0]   rd_word;
    logic                accept;
    logic                last_byte;
    logic                wr_en;
    logic [WORD_W-1:0]   wr_data;

    spireg_cmd_decode #(.NUM_RW(NUM_RW), .NUM_RO(NUM_RO)) u_decode (
        .cmd    (rx_byte),
        .kind   (dec_kind),
        .index  (dec_idx),
        .region (dec_rgn)
    );

    spireg_read_mux #(
        .NUM_RW(NUM_RW), .NUM_RO(NUM_RO), .WORD_W(WORD_W), .DEFAULT_RD(DEFAULT_RD)
    ) u_rdmux (
        .rw_flat (rw_regs_o),
        .ro_flat (ro_regs_i),
        .index   (dec_idx),
        .region  (dec_rgn),
        .word    (rd_word)
    );

    spireg_rw_bank #(.NUM_RW(NUM_RW), .WORD_W(WORD_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (tgt_idx_q),
        .wr_data   (wr_data),
        .regs_flat (rw_regs_o)
    );

    assign accept    = rx_valid && !cs_release;
    assign last_byte = (bidx_q == '0);
    assign wr_data   = {shadow_q[WORD_W-9:0], rx_byte};

    // Next-state and datapath decisions
    always_comb begin
        state_d   = state_q;
        bidx_d    = bidx_q;
        shadow_d  = shadow_q;
        tgt_idx_d = tgt_idx_q;
        tgt_rgn_d = tgt_rgn_q;
        err_d     = err_q;
        if (cs_release) begin
            state_d = ST_IDLE;
            bidx_d  = '0;
        end else if (rx_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    unique case (dec_kind)
                        CMD_STATUS: state_d = ST_SEND_STAT;
                        CMD_READ: begin
                            state_d  = ST_SEND_WORD;
                            bidx_d   = LAST_BYTE;
                            shadow_d = rd_word;
                        end
                        CMD_WRITE: begin
                            state_d   = ST_RECV_WORD;
                            bidx_d    = LAST_BYTE;
                            tgt_idx_d = dec_idx;
                            tgt_rgn_d = dec_rgn;
                        end
                        default: state_d = ST_IDLE;
                    endcase
                end
                ST_SEND_STAT: begin
                    state_d = ST_IDLE;
                    err_d   = 1'b0;
                end
                ST_SEND_WORD: begin
                    if (last_byte) begin
                        state_d = ST_IDLE;
                    end else begin
                        bidx_d = bidx_q - 1'b1;
                    end
                end
                ST_RECV_WORD: begin
                    shadow_d = wr_data;
                    if (last_byte) begin
                        state_d = ST_IDLE;
                        if (tgt_rgn_q != RGN_RW) begin
                            err_d = 1'b1;
                        end
                    end else begin
                        bidx_d = bidx_q - 1'b1;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bidx_q    <= '0;
            shadow_q  <= '0;
            tgt_idx_q <= '0;
            tgt_rgn_q <= RGN_NONE;
            err_q     <= 1'b0;
        end else begin
            state_q   <= state_d;
            bidx_q    <= bidx_d;
            shadow_q  <= shadow_d;
            tgt_idx_q <= tgt_idx_d;
            tgt_rgn_q <= tgt_rgn_d;
            err_q     <= err_d;
        end
    end

    // Outputs
    always_comb begin
        tx_byte = 8'h00;
        wr_en   = 1'b0;
        unique case (state_q)
            ST_IDLE:      tx_byte = 8'h00;
            ST_SEND_STAT: tx_byte = {7'b0, err_q};
            ST_SEND_WORD: tx_byte = shadow_q[bidx_q*8 +: 8];
            ST_RECV_WORD: wr_en   = accept && last_byte && (tgt_rgn_q == RGN_RW);
            default:      tx_byte = 8'h00;
        endcase
    end

    assert_abort_to_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cs_release |=> (state_q == ST_IDLE && bidx_q == '0));

    assert_hold_without_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !cs_release) |=> ($stable(state_q) && $stable(bidx_q)));

    assert_word_end_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_WORD && accept && last_byte) |=> state_q == ST_IDLE);

    assert_read_word_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_WORD && !cs_release) |=> $stable(shadow_q));

    assert_bad_write_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECV_WORD && accept && last_byte && tgt_rgn_q != RGN_RW) |=> err_q);

    assert_status_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND_STAT && accept) |=> (!err_q && state_q == ST_IDLE));

endmodule

// File: tb/spireg_msg_ctrl_bench.sv
module spireg_msg_ctrl_bench;
    localparam int NRW = 5;
    localparam int NRO = 3;
    localparam logic [31:0] DEF = 32'hDEADBEEF;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                rx_valid = 1'b0;
    logic [7:0]          rx_byte = 8'h00;
    logic                cs_release = 1'b0;
    logic [7:0]          tx_byte;
    logic [NRO*32-1:0]   ro_flat = '0;
    logic [NRW*32-1:0]   rw_flat;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model_rw [NRW];
    logic [31:0] model_ro [NRO];
    logic        model_err;

    always #2.5 clk = ~clk;

    spireg_msg_ctrl #(.NUM_RW(NRW), .NUM_RO(NRO), .WORD_W(32), .DEFAULT_RD(DEF)) u_spireg_msg_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_valid   (rx_valid),
        .rx_byte    (rx_byte),
        .cs_release (cs_release),
        .tx_byte    (tx_byte),
        .ro_regs_i  (ro_flat),
        .rw_regs_o  (rw_flat)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_read(input int idx);
        if (idx < NRW) return model_rw[idx];
        if (idx < NRW + NRO) return model_ro[idx - NRW];
        return DEF;
    endfunction

    task automatic set_ro(input int i, input logic [31:0] v);
        model_ro[i] = v;
        ro_flat[i*32 +: 32] = v;
    endtask

    task automatic xfer(input logic [7:0] mosi, output logic [7:0] miso);
        repeat ($urandom_range(0, 2)) @(negedge clk);
        miso = tx_byte;
        rx_byte = mosi;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic check_bank(input string req);
        for (int i = 0; i < NRW; i++) chk(req, rw_flat[i*32 +: 32], model_rw[i]);
    endtask

    task automatic do_read(input int idx);
        logic [7:0]  m;
        logic [31:0] got;
        logic [31:0] exp;
        string       tag;
        exp = exp_read(idx);
        tag = (idx < NRW) ? "R5 rw read" : (idx < NRW + NRO) ? "R5 ro read" : "R6 oob read";
        xfer({1'b0, 7'(idx)}, m);
        chk("R2 idle tx before read cmd", {24'b0, m}, 32'h0);
        chk("R2 msb presented after read cmd", {24'b0, tx_byte}, {24'b0, exp[31:24]});
        got = '0;
        for (int b = 0; b < 4; b++) begin
            xfer(8'h00, m);
            got = {got[23:0], m};
        end
        chk(tag, got, exp);
        chk("R4 idle after fourth byte", {24'b0, tx_byte}, 32'h0);
    endtask

    task automatic do_write(input int idx, input logic [31:0] data);
        logic [7:0] m;
        xfer({1'b1, 7'(idx)}, m);
        for (int b = 0; b < 4; b++) xfer(data[31-8*b -: 8], m);
        if (idx < NRW) begin
            model_rw[idx] = data;
            check_bank("R8 write commit");
        end else begin
            model_err = 1'b1;
            check_bank("R9 bad write discarded");
        end
    endtask

    task automatic do_status();
        logic [7:0] m;
        xfer(8'h7F, m);
        chk("R2 status presented", {24'b0, tx_byte}, {31'b0, model_err});
        xfer(8'h00, m);
        chk("R3 status byte", {24'b0, m}, {31'b0, model_err});
        model_err = 1'b0;
        chk("R3 idle after status", {24'b0, tx_byte}, 32'h0);
    endtask

    function automatic int pick_idx();
        if ($urandom_range(0, 3) == 0) return int'($urandom_range(NRW + NRO, 126));
        return int'($urandom_range(0, NRW + NRO - 1));
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  m;
        logic [31:0] exp;
        void'($urandom(32'd20240611));
        for (int i = 0; i < NRW; i++) model_rw[i] = '0;
        for (int i = 0; i < NRO; i++) set_ro(i, 32'h1000_0000 + 32'(i));
        model_err = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 tx after reset", {24'b0, tx_byte}, 32'h0);
        check_bank("R1 bank after reset");
        do_status();

        // Bank boundaries (R5, R6, R8, R9)
        do_write(0, 32'h0102_0304);
        do_write(NRW - 1, 32'hA5B6_C7D8);
        do_write(NRW, 32'h1111_2222);
        do_write(NRW + NRO, 32'h3333_4444);
        do_status();
        do_read(0);
        do_read(NRW - 1);
        do_read(NRW);
        do_read(NRW + NRO - 1);
        do_read(NRW + NRO);
        do_read(126);

        // R7: read-only word changes during transfer
        set_ro(1, 32'hCAFE_F00D);
        exp = exp_read(NRW + 1);
        xfer({1'b0, 7'(NRW + 1)}, m);
        // R11: no strobe for several cycles keeps the MSB presented
        repeat (3) @(negedge clk);
        chk("R11 hold without strobe", {24'b0, tx_byte}, {24'b0, exp[31:24]});
        xfer(8'h00, m);
        chk("R7 byte3", {24'b0, m}, {24'b0, exp[31:24]});
        set_ro(1, 32'h0BAD_0BAD);
        xfer(8'h00, m);
        chk("R7 byte2", {24'b0, m}, {24'b0, exp[23:16]});
        xfer(8'h00, m);
        chk("R7 byte1", {24'b0, m}, {24'b0, exp[15:8]});
        xfer(8'h00, m);
        chk("R7 byte0", {24'b0, m}, {24'b0, exp[7:0]});

        // R10: abort partial write
        xfer(8'h80, m);
        xfer(8'hEE, m);
        xfer(8'hDD, m);
        cs_release = 1'b1;
        @(negedge clk);
        cs_release = 1'b0;
        chk("R10 idle after abort", {24'b0, tx_byte}, 32'h0);
        check_bank("R10 partial write dropped");
        do_read(0);

        // R10: abort coincides with a status command while err is set
        do_write(NRW + 2, 32'h5555_6666);
        rx_byte = 8'h7F;
        rx_valid = 1'b1;
        cs_release = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        cs_release = 1'b0;
        chk("R10 strobe ignored under abort", {24'b0, tx_byte}, 32'h0);
        do_status();

        // Random traffic
        for (int n = 0; n < 300; n++) begin
            int op;
            int idx;
            op  = int'($urandom_range(0, 9));
            idx = pick_idx();
            if (op < 2) begin
                do_status();
            end else if (op < 6) begin
                set_ro(int'($urandom_range(0, NRO - 1)), $urandom());
                do_read(idx);
            end else begin
                do_write(idx, $urandom());
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule